// File: doc/BRIEF.md
# Dual-Bus Ready Synchronizer

This block merges the ready requests of two system buses into a single READY line for a processor. Each bus supplies a ready line and an active-low enable; a ready line counts only while its own enable is low. The merged (qualified) ready is brought into the processor clock domain by a pair of flip-flops. The block runs on a fast system clock and learns the processor clock's edges from two one-cycle strobes, one for each rising edge and one for each falling edge.

A mode input, which the system may change from one bus cycle to the next, selects the path. With mode low the path has two stages for devices whose ready timing is asynchronous: a ready going active is first taken into stage one at a rising-edge strobe and only reaches READY at the following falling-edge strobe, while a ready going inactive bypasses stage one and drops READY at the very next falling-edge strobe. With mode high stage one is skipped and READY takes the qualified ready at each falling-edge strobe, for devices that are guaranteed to meet setup.

Top module: `bus_ready_sync`

## Requirements
- R1: The qualified ready is high when, for some bus i, rdy_i[i] is 1 and bus_en_n_i[i] is 0; a bus whose enable is 1 has no effect on READY.
- R2: With mode_i = 0, READY becomes 1 at a fall strobe only if the qualified ready is 1 at that strobe and was also 1 at the latest rise strobe since reset.
- R3: With mode_i = 0, a fall strobe with the qualified ready at 0 drives READY to 0, whatever stage one holds.
- R4: With mode_i = 1, READY takes the value of the qualified ready at each fall strobe; the rise-strobe stage has no effect.
- R5: mode_i is sampled at each fall strobe, so the path may differ between consecutive processor cycles.
- R6: ready_o changes only on the system clock edge at which fall_stb_i is 1.
- R7: While rst_n is 0, ready_o is 0 and the rise-strobe stage is cleared; reset takes effect without a clock edge.
- R8: Strobes that arrive while reset is active are ignored: after reset is released, a mode 0 fall strobe with no rise strobe in between leaves READY at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rise_stb_i | input | 1 | One-cycle strobe marking a processor clock rising edge |
| fall_stb_i | input | 1 | One-cycle strobe marking a processor clock falling edge |
| rdy_i | input | NUM_BUS | Ready request, one per bus, active high |
| bus_en_n_i | input | NUM_BUS | Enable for each bus's ready, active low |
| mode_i | input | 1 | 0: two-stage path, 1: single-stage path |
| ready_o | output | 1 | Processor READY, updated on fall strobes |

## Verification
The assertions assume that the two strobes are never high in the same cycle and that no strobe arrives during the few cycles in which the internal reset is still being released. The bench creates its processor clock as a strict alternation of rise and fall strobes separated by random gaps of idle cycles, so the two strobes never coincide. After each reset release it waits idle cycles before the next strobe. Ready lines, enables and mode are randomized every cycle, so the mode at a fall strobe often differs from its value at the preceding rise strobe.

// File: rtl/bus_ready_sync_pkg.sv
package bus_ready_sync_pkg;
  typedef enum logic {
    PATH_TWO_STAGE = 1'b0,
    PATH_ONE_STAGE = 1'b1
  } sync_path_e;
endpackage

// File: rtl/brs_reset_sync.sv
module brs_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/brs_qualify.sv
module brs_qualify #(
  parameter int NUM_BUS = 2
) (
  input  logic [NUM_BUS-1:0] rdy_i,
  input  logic [NUM_BUS-1:0] bus_en_n_i,
  output logic               qual_o
);
  logic [NUM_BUS-1:0] per_bus;

  for (genvar g = 0; g < NUM_BUS; g++) begin : g_bus
    assign per_bus[g] = rdy_i[g] & ~bus_en_n_i[g];
  end

  assign qual_o = |per_bus;
endmodule

// File: rtl/brs_ready_stages.sv
module brs_ready_stages
  import bus_ready_sync_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rise_stb_i,
  input  logic fall_stb_i,
  input  logic qual_i,
  input  logic mode_i,
  output logic stage1_o,
  output logic ready_o
);
  sync_path_e path;
  logic s1_q, s1_d, s1_en;
  logic s2_q, s2_d, s2_en;

  assign path = sync_path_e'(mode_i);

  always_comb begin
    s1_en = rise_stb_i;
    s1_d  = qual_i;
    s2_en = fall_stb_i;
    case (path)
      PATH_ONE_STAGE: s2_d = qual_i;
      default:        s2_d = qual_i & s1_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
    end else if (s1_en) begin
      s1_q <= s1_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_q <= 1'b0;
    end else if (s2_en) begin
      s2_q <= s2_d;
    end
  end

  assign stage1_o = s1_q;
  assign ready_o  = s2_q;
endmodule

// File: rtl/bus_ready_sync.sv
module bus_ready_sync #(
  parameter int NUM_BUS    = 2,
  parameter int RST_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rise_stb_i,
  input  logic               fall_stb_i,
  input  logic [NUM_BUS-1:0] rdy_i,
  input  logic [NUM_BUS-1:0] bus_en_n_i,
  input  logic               mode_i,
  output logic               ready_o
);
  logic rst_int_n;
  logic rst_comb_n;
  logic qual;
  logic stage1_q;

  brs_reset_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  // Assertion reaches the registers at once; release follows the synchronizer.
  assign rst_comb_n = rst_int_n & rst_n;

  brs_qualify #(.NUM_BUS(NUM_BUS)) u_qual (
    .rdy_i      (rdy_i),
    .bus_en_n_i (bus_en_n_i),
    .qual_o     (qual)
  );

  brs_ready_stages u_stages (
    .clk        (clk),
    .rst_n      (rst_comb_n),
    .rise_stb_i (rise_stb_i),
    .fall_stb_i (fall_stb_i),
    .qual_i     (qual),
    .mode_i     (mode_i),
    .stage1_o   (stage1_q),
    .ready_o    (ready_o)
  );
endmodule

// File: rtl/bus_ready_sync_chk.sv
module bus_ready_sync_chk #(
  parameter int NUM_BUS = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rst_int_n,
  input logic               rise_stb_i,
  input logic               fall_stb_i,
  input logic [NUM_BUS-1:0] rdy_i,
  input logic [NUM_BUS-1:0] bus_en_n_i,
  input logic               mode_i,
  input logic               stage1,
  input logic               ready_o
);
  logic q_ports;
  assign q_ports = |(rdy_i & ~bus_en_n_i);

  assert_change_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_int_n || !rst_n)
    !fall_stb_i |=> $stable(ready_o));

  assert_two_stage_rise_R2: assert property (@(posedge clk) disable iff (!rst_int_n || !rst_n)
    (fall_stb_i && !mode_i && q_ports) |=> (ready_o == $past(stage1)));

  assert_drop_direct_R3: assert property (@(posedge clk) disable iff (!rst_int_n || !rst_n)
    (fall_stb_i && !q_ports) |=> !ready_o);

  assert_one_stage_R4: assert property (@(posedge clk) disable iff (!rst_int_n || !rst_n)
    (fall_stb_i && mode_i) |=> (ready_o == $past(q_ports)));

  assert_reset_clears_R7: assert property (@(posedge clk)
    !rst_n |-> (!ready_o && !stage1));

  assert_reset_strobes_ignored_R8: assert property (@(posedge clk)
    !rst_int_n |=> !stage1);

  // Input assumption: strobes are exclusive (supports R6 accounting).
  assert_strobes_apart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_stb_i && fall_stb_i));
endmodule

bind bus_ready_sync bus_ready_sync_chk #(.NUM_BUS(NUM_BUS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_int_n  (rst_int_n),
  .rise_stb_i (rise_stb_i),
  .fall_stb_i (fall_stb_i),
  .rdy_i      (rdy_i),
  .bus_en_n_i (bus_en_n_i),
  .mode_i     (mode_i),
  .stage1     (stage1_q),
  .ready_o    (ready_o)
);

// File: tb/test_bus_ready_sync.sv
`timescale 1ns/1ps
module test_bus_ready_sync;
  localparam int NB = 2;

  logic          clk;
  logic          rst_n;
  logic          rise_stb, fall_stb;
  logic [NB-1:0] rdy, en_n;
  logic          mode;
  logic          ready;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // Requirement-level reference: rise stage and READY.
  logic ref_s1, ref_rdy;
  string last_tag = "R6";

  bus_ready_sync #(.NUM_BUS(NB)) i_bus_ready_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rise_stb_i (rise_stb),
    .fall_stb_i (fall_stb),
    .rdy_i      (rdy),
    .bus_en_n_i (en_n),
    .mode_i     (mode),
    .ready_o    (ready)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic qual_of(logic [NB-1:0] r, logic [NB-1:0] e);
    logic q = 1'b0;
    for (int i = 0; i < NB; i++) q |= r[i] & ~e[i];
    return q;
  endfunction

  function automatic logic next_ready(logic m, logic q, logic s1);
    if (m) return q;      // R4 single stage
    if (!q) return 1'b0;  // R3 direct drop
    return s1;            // R2 needs earlier rise capture
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_s1  <= 1'b0;
      ref_rdy <= 1'b0;
    end else begin
      if (fall_stb) begin
        ref_rdy  <= next_ready(mode, qual_of(rdy, en_n), ref_s1);
        last_tag <= mode ? "R4" : (qual_of(rdy, en_n) ? "R2" : "R3");
      end else begin
        last_tag <= "R6";
      end
      if (rise_stb) ref_s1 <= qual_of(rdy, en_n);
    end
  end

  task automatic check(string tag, logic exp);
    total++;
    if (ready !== exp) begin
      bad++;
      $display("FAIL %s ready actual=%b expected=%b at %0t", tag, ready, exp, $time);
    end
  endtask

  // Called at a negedge: drive, pass a posedge, check at the next negedge.
  task automatic step(logic [NB-1:0] r, logic [NB-1:0] e, logic m,
                      logic rs, logic fs);
    rdy = r; en_n = e; mode = m; rise_stb = rs; fall_stb = fs;
    @(posedge clk);
    @(negedge clk);
    check(last_tag, ref_rdy);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(2'b00, 2'b11, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #1;
    total++;
    if (ready !== 1'b0) begin
      bad++;
      $display("FAIL R7 async clear actual=%b expected=0", ready);
    end
    @(negedge clk);
    rst_n = 1'b1;
    idle(4);
  endtask

  initial begin
    void'($urandom(32'h1c0ffee5));
    rst_n = 1'b0; rise_stb = 0; fall_stb = 0; rdy = '0; en_n = '1; mode = 0;
    repeat (2) @(negedge clk);

    // R7 reset state, R8 strobes during reset ignored
    rdy = 2'b11; en_n = 2'b00; mode = 1; rise_stb = 1;
    @(negedge clk); rise_stb = 0; fall_stb = 1;
    @(negedge clk); fall_stb = 0;
    check("R7", 1'b0);
    rst_n = 1'b1;
    idle(4);
    check("R7", 1'b0);
    step(2'b11, 2'b00, 1'b0, 1'b0, 1'b1);
    check("R8", 1'b0);

    // R1: enabled high hides the ready line; each bus alone works
    step(2'b01, 2'b01, 1'b1, 1'b0, 1'b1); check("R1", 1'b0);
    step(2'b01, 2'b10, 1'b1, 1'b0, 1'b1); check("R1", 1'b1);
    step(2'b10, 2'b10, 1'b1, 1'b0, 1'b1); check("R1", 1'b0);
    step(2'b10, 2'b01, 1'b1, 1'b0, 1'b1); check("R1", 1'b1);

    // R3: mode 0 drop is direct even though stage one holds 1
    step(2'b01, 2'b00, 1'b0, 1'b1, 1'b0); check("R6", 1'b1);
    step(2'b00, 2'b00, 1'b0, 1'b0, 1'b1); check("R3", 1'b0);

    // R2: rise stage low -> fall does not raise READY; then rise then fall does
    step(2'b00, 2'b00, 1'b0, 1'b1, 1'b0);
    step(2'b01, 2'b00, 1'b0, 1'b0, 1'b1); check("R2", 1'b0);
    step(2'b01, 2'b00, 1'b0, 1'b1, 1'b0); check("R6", 1'b0);
    step(2'b01, 2'b00, 1'b0, 1'b0, 1'b0); check("R6", 1'b0);
    step(2'b01, 2'b00, 1'b0, 1'b0, 1'b1); check("R2", 1'b1);

    // R5: mode switched between rise and fall
    step(2'b00, 2'b00, 1'b0, 1'b1, 1'b0);
    step(2'b00, 2'b00, 1'b0, 1'b0, 1'b1); check("R5", 1'b0);
    step(2'b00, 2'b11, 1'b0, 1'b1, 1'b0);
    step(2'b10, 2'b00, 1'b1, 1'b0, 1'b1); check("R5", 1'b1);
    step(2'b10, 2'b00, 1'b0, 1'b0, 1'b1); check("R5", 1'b0);

    // Random strobe train, strict rise/fall alternation with idle gaps
    begin
      bit next_is_rise = 1;
      for (int n = 0; n < 3000; n++) begin
        int gap = $urandom_range(0, 3);
        for (int g = 0; g < gap; g++)
          step(2'($urandom), 2'($urandom), 1'($urandom), 1'b0, 1'b0);
        step(2'($urandom), 2'($urandom), 1'($urandom), next_is_rise, !next_is_rise);
        next_is_rise = !next_is_rise;
        if (n == 1500) do_reset();
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule